// File: doc/BRIEF.md
# XT Bus Cycle Sequencer

This block is a bus master that turns single transfer requests into 8-bit XT-style bus cycles over a 20-bit address space. A request carries an address, a direction flag, a memory-or-port flag and a write byte. When the block is idle it takes the request and runs the fixed phase order T1, T2, T3 and T4. It drives the address latch strobe, one of four active-low command strobes, the address lines and the outgoing data byte.

A slow target holds the ready input low to stretch the cycle. The sequencer then repeats a wait phase (Tw) after T3 until ready returns high. The byte the target returns is captured on the clock edge that ends the last T3 or Tw phase. It is presented together with a one-clock completion pulse during T4. Port cycles carry only a 16-bit port number, and the upper address lines are held at zero.

Top module: `xtbus_seq`

## Requirements
- R1: After reset and whenever idle, all four command strobes are high, the latch strobe `bus_ale` is low, `rsp_done` is low, `bus_data_oe` is low, `bus_addr` is zero and `req_ready` is high.
- R2: In the first clock after a request is accepted (T1), `bus_ale` is high, `bus_addr` carries the request address and all command strobes are still high.
- R3: In T2 `bus_ale` is low and exactly one strobe goes low, chosen by {io, write}: 0 = `bus_memr_n`, 1 = `bus_memw_n`, 2 = `bus_ior_n`, 3 = `bus_iow_n`.
- R4: At most one command strobe is low in any clock. A strobe is low only in T2, T3 and Tw, and all strobes are high in T4.
- R5: With ready high at the end of T3, the cycle takes exactly four clocks, and `rsp_done` is high in the fourth clock after acceptance.
- R6: Ready is sampled only at the end of T3 and Tw. When it is low, one more Tw clock follows with the strobe still low. When it is high, T4 follows. Ready is ignored in T1 and T2.
- R7: For writes, `bus_data_oe` is high and `bus_data_out` carries the request byte from T2 through T4. For reads, `bus_data_oe` stays low.
- R8: For reads, the byte on `bus_data_in` at the edge that ends the last T3/Tw clock appears on `rsp_rdata` during T4 and is held afterwards. Changes to `bus_data_in` in T4 have no effect.
- R9: A request is accepted only while idle (`req_ready` high). Its fields are latched at acceptance, so later changes to the request inputs do not alter the running cycle. A request raised during T4 starts nothing until the block has spent one clock idle.
- R10: `rsp_done` is high for exactly one clock per cycle, during T4.
- R11: For port cycles, `bus_addr` carries the low 16 request address bits and its upper 4 bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request |
| req_addr | input | 20 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = port cycle, 0 = memory cycle |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | High while idle; a request is accepted on this clock |
| bus_addr | output | 20 | Address lines |
| bus_ale | output | 1 | Address latch strobe, high in T1 |
| bus_memr_n | output | 1 | Memory read strobe, active low |
| bus_memw_n | output | 1 | Memory write strobe, active low |
| bus_ior_n | output | 1 | Port read strobe, active low |
| bus_iow_n | output | 1 | Port write strobe, active low |
| bus_data_out | output | 8 | Outgoing data byte |
| bus_data_oe | output | 1 | Data output enable |
| bus_data_in | input | 8 | Incoming data byte |
| bus_rdy | input | 1 | Target ready; low inserts wait phases |
| rsp_done | output | 1 | One-clock completion pulse in T4 |
| rsp_rdata | output | 8 | Captured read byte |

## Verification
Two functions can fall in the same clock: the completion of one cycle in T4, and a new request arriving for the next cycle. The bench raises a fresh request in the T4 clock of a long wait-state read. It then judges that the following clock is idle, with the latch strobe low and the address lines at zero, and that T1 of the new request starts only one clock later with the new address. A second overlap, where ready returns on the same edge that captures read data, is provoked by changing the input byte right after that edge. The test passes only if the byte from before the edge appears on `rsp_rdata`.

// File: rtl/xtbus_pkg.sv
package xtbus_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_T1   = 3'd1,
      PH_T2   = 3'd2,
      PH_T3   = 3'd3,
      PH_TW   = 3'd4,
      PH_T4   = 3'd5
   } phase_e;

   // command code = {io, write}
   typedef enum logic [1:0] {
      CMD_MEM_RD = 2'd0,
      CMD_MEM_WR = 2'd1,
      CMD_IO_RD  = 2'd2,
      CMD_IO_WR  = 2'd3
   } cmd_e;
endpackage

// File: rtl/xtbus_phase_fsm.sv
module xtbus_phase_fsm
   import xtbus_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   rdy,
   output phase_e phase,
   output logic   capture
);
   phase_e phase_q, phase_d;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE: if (start) phase_d = PH_T1;
         PH_T1:   phase_d = PH_T2;
         PH_T2:   phase_d = PH_T3;
         PH_T3,
         PH_TW:   phase_d = rdy ? PH_T4 : PH_TW;
         PH_T4:   phase_d = PH_IDLE;
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   assign phase   = phase_q;
   assign capture = ((phase_q == PH_T3) || (phase_q == PH_TW)) && rdy;

   // R6: ready low in T3/Tw stretches the cycle by one more Tw
   p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (((phase_q == PH_T3) || (phase_q == PH_TW)) && !rdy) |=> (phase_q == PH_TW));
   // R6: ready high in T3/Tw moves on to T4
   p_wait_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (((phase_q == PH_T3) || (phase_q == PH_TW)) && rdy) |=> (phase_q == PH_T4));
   // R9: T1 is only ever entered from idle
   p_t1_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE) |=> (phase_q != PH_T1));
endmodule

// File: rtl/xtbus_strobe_dec.sv
module xtbus_strobe_dec
   import xtbus_pkg::*;
#(
   parameter int N_CMD = 4,
   localparam int CMD_W = $clog2(N_CMD)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  phase_e           phase,
   input  logic [CMD_W-1:0] cmd,
   output logic             ale,
   output logic [N_CMD-1:0] strobe_n
);
   logic cmd_on;

   assign ale    = (phase == PH_T1);
   assign cmd_on = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW);

   for (genvar gi = 0; gi < N_CMD; gi++) begin : g_strobe
      assign strobe_n[gi] = !(cmd_on && (cmd == CMD_W'(gi)));
   end

   // R4: never more than one strobe active
   p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~strobe_n) <= 1);
   // R2: latch strobe and command strobes never overlap
   p_ale_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (&strobe_n));
   // R4: strobes are released in T4
   p_t4_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_T4) |-> (&strobe_n));
endmodule

// File: rtl/xtbus_seq.sv
module xtbus_seq
   import xtbus_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int IO_ADDR_W  = 16,
   parameter int DATA_W     = 8,
   parameter bit RDATA_HOLD = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_io,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_ale,
   output logic              bus_memr_n,
   output logic              bus_memw_n,
   output logic              bus_ior_n,
   output logic              bus_iow_n,
   output logic [DATA_W-1:0] bus_data_out,
   output logic              bus_data_oe,
   input  logic [DATA_W-1:0] bus_data_in,
   input  logic              bus_rdy,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata
);
   localparam int N_CMD  = 4;
   localparam int CMD_W  = $clog2(N_CMD);
   localparam int HI_W   = ADDR_W - IO_ADDR_W;

   if (IO_ADDR_W >= ADDR_W) begin : g_bad_io_width
      $error("IO_ADDR_W must be narrower than ADDR_W");
   end
   if (DATA_W < 1) begin : g_bad_data_width
      $error("DATA_W must be positive");
   end

   phase_e            phase;
   logic              capture;
   logic              accept;
   logic [ADDR_W-1:0] addr_q;
   logic [CMD_W-1:0]  cmd_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic [N_CMD-1:0]  strobe_n;

   assign req_ready = (phase == PH_IDLE);
   assign accept    = req_ready && req_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         cmd_q   <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_io ? {{HI_W{1'b0}}, req_addr[IO_ADDR_W-1:0]} : req_addr;
         cmd_q   <= {req_io, req_write};
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_q <= '0;
      else if (capture) rdata_q <= bus_data_in;
   end

   xtbus_phase_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .rdy     (bus_rdy),
      .phase   (phase),
      .capture (capture)
   );

   xtbus_strobe_dec #(.N_CMD(N_CMD)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase    (phase),
      .cmd      (cmd_q),
      .ale      (bus_ale),
      .strobe_n (strobe_n)
   );

   assign bus_memr_n = strobe_n[CMD_MEM_RD];
   assign bus_memw_n = strobe_n[CMD_MEM_WR];
   assign bus_ior_n  = strobe_n[CMD_IO_RD];
   assign bus_iow_n  = strobe_n[CMD_IO_WR];

   assign bus_addr     = (phase == PH_IDLE) ? '0 : addr_q;
   assign bus_data_oe  = cmd_q[0] && (phase != PH_IDLE) && (phase != PH_T1);
   assign bus_data_out = bus_data_oe ? wdata_q : '0;
   assign rsp_done     = (phase == PH_T4);

   if (RDATA_HOLD) begin : g_rdata_hold
      assign rsp_rdata = rdata_q;
   end else begin : g_rdata_gate
      assign rsp_rdata = rsp_done ? rdata_q : '0;
   end

   // R10: completion lasts one clock
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
   // R9: an accepted request opens with the latch strobe
   p_accept_ale_r9: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> bus_ale);
   // R7: data is never driven during the address phase
   p_oe_no_ale_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_data_oe |-> !bus_ale);
   // R11: port cycles keep the upper address lines at zero
   p_io_upper_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q[1] && !req_ready) |-> (bus_addr[ADDR_W-1:IO_ADDR_W] == '0));
   // R1: idle bus is quiet
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!bus_ale && !bus_data_oe && !rsp_done && (&strobe_n)));
endmodule

// File: tb/xtbus_seq_tb_top.sv
module xtbus_seq_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [19:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        req_io = 1'b0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready;
   logic [19:0] bus_addr;
   logic        bus_ale;
   logic        bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n;
   logic [7:0]  bus_data_out;
   logic        bus_data_oe;
   logic [7:0]  bus_data_in = '0;
   logic        bus_rdy = 1'b1;
   logic        rsp_done;
   logic [7:0]  rsp_rdata;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   xtbus_seq dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
      .req_io(req_io), .req_wdata(req_wdata), .req_ready(req_ready),
      .bus_addr(bus_addr), .bus_ale(bus_ale),
      .bus_memr_n(bus_memr_n), .bus_memw_n(bus_memw_n),
      .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n),
      .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
      .bus_data_in(bus_data_in), .bus_rdy(bus_rdy),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
   );

   function automatic logic [3:0] strobes();
      return {bus_iow_n, bus_ior_n, bus_memw_n, bus_memr_n};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_idle(input string tag);
      chk(strobes() == 4'hF, "R1", {tag, " strobes"}, strobes(), 4'hF);
      chk(!bus_ale && !rsp_done && !bus_data_oe, "R1", {tag, " ale/done/oe"},
          {bus_ale, rsp_done, bus_data_oe}, 0);
      chk(bus_addr == 0, "R1", {tag, " addr"}, bus_addr, 0);
      chk(req_ready, "R9", {tag, " ready"}, req_ready, 1);
   endtask

   // One full cycle; caller is at a negedge with the block idle.
   task automatic run_cycle(input logic [19:0] a, input bit wr, input bit io,
                            input logic [7:0] wd, input logic [7:0] rd,
                            input int waits, input bit chain, input logic [19:0] nx_a);
      logic [19:0] ea;
      logic [3:0]  es;
      ea = io ? {4'h0, a[15:0]} : a;
      es = 4'hF & ~(4'h1 << {io, wr});
      req_valid = 1; req_addr = a; req_write = wr; req_io = io; req_wdata = wd;
      bus_rdy = 1; bus_data_in = rd;
      @(negedge clk); // T1
      chk(bus_ale, "R2", "T1 ale", bus_ale, 1);
      chk(strobes() == 4'hF, "R2", "T1 strobes", strobes(), 4'hF);
      chk(bus_addr == ea, io ? "R11" : "R2", "T1 addr", bus_addr, ea);
      chk(!req_ready, "R9", "T1 busy", req_ready, 0);
      req_valid = 0; req_addr = ~a; req_wdata = ~wd; req_write = ~wr;
      bus_rdy = 0; // ignored in T1/T2
      @(negedge clk); // T2
      chk(!bus_ale, "R3", "T2 ale", bus_ale, 0);
      chk(strobes() == es, "R3", "T2 strobe", strobes(), es);
      chk(bus_data_oe == wr, "R7", "T2 oe", bus_data_oe, wr);
      if (wr) chk(bus_data_out == wd, "R9", "T2 latched wdata", bus_data_out, wd);
      chk(bus_addr == ea, "R9", "T2 latched addr", bus_addr, ea);
      bus_rdy = 1;
      @(negedge clk); // T3
      chk(strobes() == es, "R4", "T3 strobe", strobes(), es);
      chk(!rsp_done, "R5", "T3 no done", rsp_done, 0);
      bus_rdy = (waits == 0);
      for (int k = 1; k <= waits; k++) begin
         @(negedge clk); // Tw k
         chk(strobes() == es, "R6", "Tw strobe held", strobes(), es);
         chk(!rsp_done, "R6", "Tw no done", rsp_done, 0);
         bus_rdy = (k == waits);
      end
      @(negedge clk); // T4
      bus_data_in = ~rd;
      bus_rdy = 0;
      chk(rsp_done, (waits == 0) ? "R5" : "R6", "T4 done", rsp_done, 1);
      chk(strobes() == 4'hF, "R4", "T4 strobes high", strobes(), 4'hF);
      chk(bus_data_oe == wr, "R7", "T4 oe", bus_data_oe, wr);
      if (!wr) chk(rsp_rdata == rd, "R8", "T4 rdata", rsp_rdata, rd);
      if (chain) begin
         req_valid = 1; req_addr = nx_a; req_write = 0; req_io = 0;
      end
      @(negedge clk); // idle
      chk(!rsp_done, "R10", "done single clock", rsp_done, 0);
      chk(!bus_ale && bus_addr == 0, "R9", "idle after T4", {bus_ale, bus_addr}, 0);
      chk(req_ready, "R9", "ready again", req_ready, 1);
      chk(strobes() == 4'hF, "R1", "idle strobes", strobes(), 4'hF);
      if (!wr) chk(rsp_rdata == rd, "R8", "rdata held", rsp_rdata, rd);
      bus_rdy = 1;
   endtask

   task automatic t_reset();
      #1;
      chk_idle("in reset");
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      @(negedge clk); @(negedge clk);
      chk_idle("after reset");
   endtask

   task automatic t_mem_read();  run_cycle(20'hA5C31, 0, 0, 8'h00, 8'h3C, 0, 0, 0); endtask
   task automatic t_mem_write(); run_cycle(20'hF0F0F, 1, 0, 8'hA7, 8'h55, 0, 0, 0); endtask
   task automatic t_io_read();   run_cycle(20'hB03F8, 0, 1, 8'h00, 8'hC9, 2, 0, 0); endtask
   task automatic t_io_write();  run_cycle(20'hE1234, 1, 1, 8'h5E, 8'h00, 1, 0, 0); endtask
   task automatic t_overlap();
      run_cycle(20'h12345, 0, 0, 8'h00, 8'h81, 5, 1, 20'h6789A);
      run_cycle(20'h6789A, 0, 0, 8'h00, 8'h4D, 0, 0, 0);
   endtask

   initial begin
      t_reset();
      t_mem_read();
      t_mem_write();
      t_io_read();
      t_io_write();
      t_overlap();
      @(negedge clk);
      chk_idle("end");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 5000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule